// File: doc/BRIEF.md
# Cascadable Circular Sample Write Controller

This block is the digital write-side sequencer of a multi-channel circular sampling array. A single sampling wave walks through the cells of the array one cell per clock. The channels can be partitioned into groups of 1, 2, 4 or 8 consecutive channels. Within a group, only one channel is written at a time. When that channel's last cell has been written, the wave moves on to the next channel of the same group. This gives rings of 1, 2, 4 or 8 channel lengths. At the end of the last channel of a group the wave wraps back to the first channel of the group.

In cascade mode the wave does not wrap. It leaves the device through a one-cycle chain output and re-enters through a chain input, so several devices can be daisy-chained into one deeper ring. A stop request freezes the wave. The block then reports the group-relative cell index at which sampling halted, so the sampled record can be read back in time order. A free-running test mode ignores stop requests. The partition and cascade choice are taken only while the device is stopped.

Top module: `casc_ring_wr`

## Requirements
- R1: After reset the block is stopped: all channel write enables are 0, the cell index is 0, `running`, `chain_out` and `stop_valid` are 0.
- R2: From the stopped state, a high `arm_start` at a clock edge starts the wave. From the next cycle `running` is 1, the cell index is 0 and the first channel of every group is enabled. `part_sel` value k selects groups of 2^k consecutive channels (0: eight groups of one channel, 3: one group of eight).
- R3: While running, the cell index rises by one per cycle. After cell CELLS-1 of a channel that is not the last of its group, the next cycle writes cell 0 of the next channel in the group.
- R4: With cascade off, cell CELLS-1 of the last channel of a group is followed by cell 0 of the first channel of that group.
- R5: Channel c is write-enabled exactly when the wave is running on this device and c mod 2^k equals the position of the active channel within its group.
- R6: With cascade on, the wave leaves the device after the last cell of the last channel. `chain_out` is high for exactly one cycle, all enables drop, and the device waits. A `chain_in` pulse while waiting, or while stopped with `cascade_en` high, restarts the wave at cell 0 of the first channel.
- R7: With `cascade_en` low, `chain_in` is ignored by a stopped device.
- R8: A stop request while running halts the wave from the next cycle. It gives a one-cycle `stop_valid` with `stop_pos` = channel-in-group × CELLS + cell index of the cycle in which the stop was sampled.
- R9: A stop that falls in the same cycle as the end of a channel or of the ring takes priority: no hand-off, no wrap, no `chain_out`, and `stop_pos` reports that last cell.
- R10: Changes of `part_sel` or `cascade_en` while running or waiting have no effect. The values are taken only while stopped.
- R11: With `free_run` high, stop requests are ignored and the wave keeps running.
- R12: A stop while waiting returns the device to the stopped state without `stop_valid`, even if `chain_in` arrives in the same cycle.
- R13: `arm_start` while running has no effect on the wave position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_start | input | 1 | Start the wave from the stopped state |
| stop_req | input | 1 | Stop request |
| part_sel | input | SEL_W | Group size exponent k (groups of 2^k channels) |
| cascade_en | input | 1 | Route the ring end to the chain output |
| free_run | input | 1 | Ignore stop requests |
| chain_in | input | 1 | Wave entry from the previous device |
| ch_wen | output | NUM_CH | Per-channel write enables |
| cell_idx | output | CELL_W | Cell being written in the active channels |
| running | output | 1 | Wave is present on this device |
| chain_out | output | 1 | One-cycle wave hand-off to the next device |
| stop_valid | output | 1 | One-cycle pulse when a stop halted the wave here |
| stop_pos | output | POS_W | Group-relative cell index at stop |

## Verification
A stop request and the end of a channel, or the end of the ring, can land in the same clock edge. In cascade mode, a stop and a `chain_in` can also meet while the device is waiting. The bench provokes the first by watching `cell_idx` reach the last cell and raising the stop for that edge, in both the hand-off and wrap positions. It provokes the second by pulsing stop and chain input together after a hand-off. A cycle-level bench model that tracks the ring position judges every cycle. It expects the stop to win, with no `chain_out`, the last cell as `stop_pos`, and no restart.

// File: rtl/casc_ring_pkg.sv
package casc_ring_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } wave_st_e;
endpackage

// File: rtl/casc_ring_cfg.sv
module casc_ring_cfg #(
  parameter int NUM_CH = 8,
  parameter int SEL_W  = 2,
  localparam int MEM_W = $clog2(NUM_CH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SEL_W-1:0] part_in,
  input  logic             casc_in,
  output logic             casc_q,
  output logic [MEM_W-1:0] mask_q,
  output logic [MEM_W-1:0] mask_nxt
);
  logic [SEL_W-1:0] part_q;

  function automatic logic [MEM_W-1:0] sel_mask(input logic [SEL_W-1:0] k);
    int kk;
    kk = (int'(k) > MEM_W) ? MEM_W : int'(k);
    return MEM_W'((1 << kk) - 1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      part_q <= '0;
      casc_q <= 1'b0;
    end else if (load) begin
      part_q <= part_in;
      casc_q <= casc_in;
    end
  end

  assign mask_q   = sel_mask(part_q);
  assign mask_nxt = load ? sel_mask(part_in) : mask_q;

  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(part_q) && $stable(casc_q)));
endmodule

// File: rtl/casc_ring_seq.sv
module casc_ring_seq
  import casc_ring_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CELLS  = 1024,
  localparam int MEM_W = $clog2(NUM_CH),
  localparam int CELL_W = $clog2(CELLS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm_start,
  input  logic              stop_req,
  input  logic              free_run,
  input  logic              chain_in,
  input  logic              cascade_live,
  input  logic              casc_q,
  input  logic [MEM_W-1:0]  mask_q,
  output logic              idle,
  output logic              run_cur,
  output logic              run_nxt,
  output logic [MEM_W-1:0]  mem_nxt,
  output logic [MEM_W-1:0]  mem_q,
  output logic [CELL_W-1:0] cell_q,
  output logic              stop_hit,
  output logic              chain_out_q
);
  localparam logic [CELL_W-1:0] CELL_LAST = CELL_W'(CELLS - 1);

  wave_st_e          st_q, st_n;
  logic [CELL_W-1:0] cell_n;
  logic              chain_n;
  logic              stop_eff;
  logic              last_cell, last_mem;

  assign stop_eff  = stop_req && !free_run;
  assign last_cell = (cell_q == CELL_LAST);
  assign last_mem  = (mem_q == mask_q);

  always_comb begin
    st_n     = st_q;
    cell_n   = '0;
    mem_nxt  = '0;
    chain_n  = 1'b0;
    stop_hit = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (arm_start || (cascade_live && chain_in)) st_n = ST_RUN;
      end
      ST_RUN: begin
        if (stop_eff) begin
          st_n     = ST_IDLE;
          stop_hit = 1'b1;
        end else if (!last_cell) begin
          cell_n  = cell_q + 1'b1;
          mem_nxt = mem_q;
        end else if (!last_mem) begin
          mem_nxt = mem_q + 1'b1;
        end else if (casc_q) begin
          st_n    = ST_WAIT;
          chain_n = 1'b1;
        end
      end
      ST_WAIT: begin
        if (stop_eff)      st_n = ST_IDLE;
        else if (chain_in) st_n = ST_RUN;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      cell_q      <= '0;
      mem_q       <= '0;
      chain_out_q <= 1'b0;
    end else begin
      st_q        <= st_n;
      cell_q      <= cell_n;
      mem_q       <= mem_nxt;
      chain_out_q <= chain_n;
    end
  end

  assign idle    = (st_q == ST_IDLE);
  assign run_cur = (st_q == ST_RUN);
  assign run_nxt = (st_n == ST_RUN);

  a_r3_cell_step: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && !stop_eff && !last_cell) |=>
      (st_q == ST_RUN && cell_q == CELL_W'($past(cell_q) + 1'b1)));
  a_r8_stop_halts: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && stop_eff) |=> (st_q == ST_IDLE && cell_q == '0));
  a_r11_free_keeps: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && free_run) |=> (st_q != ST_IDLE));
  a_r6_chain_single: assert property (@(posedge clk) disable iff (rst)
    chain_out_q |=> !chain_out_q);
  a_r6_chain_waits: assert property (@(posedge clk) disable iff (rst)
    chain_out_q |-> (st_q == ST_WAIT));
endmodule

// File: rtl/casc_ring_wen.sv
module casc_ring_wen #(
  parameter int NUM_CH = 8,
  localparam int MEM_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_cur,
  input  logic              run_nxt,
  input  logic [MEM_W-1:0]  mem_nxt,
  input  logic [MEM_W-1:0]  mask_nxt,
  output logic [NUM_CH-1:0] wen_q
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) wen_q[c] <= 1'b0;
      else     wen_q[c] <= run_nxt && ((MEM_W'(c) & mask_nxt) == mem_nxt);
    end
  end

  a_r5_off_when_idle: assert property (@(posedge clk) disable iff (rst)
    !run_cur |-> (wen_q == '0));
  a_r5_some_when_run: assert property (@(posedge clk) disable iff (rst)
    run_cur |-> ($countones(wen_q) >= 1));
endmodule

// File: rtl/casc_ring_stop.sv
module casc_ring_stop #(
  parameter int NUM_CH = 8,
  parameter int CELLS  = 1024,
  localparam int MEM_W = $clog2(NUM_CH),
  localparam int CELL_W = $clog2(CELLS),
  localparam int POS_W = MEM_W + CELL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stop_hit,
  input  logic [MEM_W-1:0]  mem_q,
  input  logic [CELL_W-1:0] cell_q,
  input  logic              run_cur,
  output logic              valid_q,
  output logic [POS_W-1:0]  pos_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      pos_q   <= '0;
    end else begin
      valid_q <= stop_hit;
      if (stop_hit) pos_q <= {mem_q, cell_q};
    end
  end

  a_r8_valid_after_run: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> !run_cur);
  a_r12_no_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !run_cur |=> !valid_q);
endmodule

// File: rtl/casc_ring_wr.sv
module casc_ring_wr #(
  parameter int NUM_CH = 8,
  parameter int CELLS  = 1024,
  parameter int SEL_W  = $clog2($clog2(NUM_CH) + 1),
  localparam int MEM_W = $clog2(NUM_CH),
  localparam int CELL_W = $clog2(CELLS),
  localparam int POS_W = MEM_W + CELL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm_start,
  input  logic              stop_req,
  input  logic [SEL_W-1:0]  part_sel,
  input  logic              cascade_en,
  input  logic              free_run,
  input  logic              chain_in,
  output logic [NUM_CH-1:0] ch_wen,
  output logic [CELL_W-1:0] cell_idx,
  output logic              running,
  output logic              chain_out,
  output logic              stop_valid,
  output logic [POS_W-1:0]  stop_pos
);
  logic             idle, run_cur, run_nxt, stop_hit, casc_q;
  logic [MEM_W-1:0] mask_q, mask_nxt, mem_nxt, mem_q;

  casc_ring_cfg #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_cfg (
    .clk(clk), .rst(rst), .load(idle), .part_in(part_sel), .casc_in(cascade_en),
    .casc_q(casc_q), .mask_q(mask_q), .mask_nxt(mask_nxt));

  casc_ring_seq #(.NUM_CH(NUM_CH), .CELLS(CELLS)) u_seq (
    .clk(clk), .rst(rst), .arm_start(arm_start), .stop_req(stop_req),
    .free_run(free_run), .chain_in(chain_in), .cascade_live(cascade_en),
    .casc_q(casc_q), .mask_q(mask_q), .idle(idle), .run_cur(run_cur),
    .run_nxt(run_nxt), .mem_nxt(mem_nxt), .mem_q(mem_q), .cell_q(cell_idx),
    .stop_hit(stop_hit), .chain_out_q(chain_out));

  casc_ring_wen #(.NUM_CH(NUM_CH)) u_wen (
    .clk(clk), .rst(rst), .run_cur(run_cur), .run_nxt(run_nxt),
    .mem_nxt(mem_nxt), .mask_nxt(mask_nxt), .wen_q(ch_wen));

  casc_ring_stop #(.NUM_CH(NUM_CH), .CELLS(CELLS)) u_stop (
    .clk(clk), .rst(rst), .stop_hit(stop_hit), .mem_q(mem_q), .cell_q(cell_idx),
    .run_cur(run_cur), .valid_q(stop_valid), .pos_q(stop_pos));

  assign running = run_cur;

  a_r4_wrap_in_group: assert property (@(posedge clk) disable iff (rst)
    (running && !casc_q && !(stop_req && !free_run) && cell_idx == CELL_W'(CELLS - 1)
      && mem_q == mask_q) |=> (running && cell_idx == '0 && mem_q == '0));
endmodule

// File: tb/sim_casc_ring_wr.sv
module sim_casc_ring_wr;
  localparam int NCH = 8;
  localparam int CELLS = 16;
  localparam int CW = $clog2(CELLS);
  localparam int PW = $clog2(NCH) + CW;

  logic clk = 1'b0, rst = 1'b1;
  logic arm_start = 0, stop_req = 0, cascade_en = 0, free_run = 0, chain_in = 0;
  logic [1:0] part_sel = 0;
  logic [NCH-1:0] ch_wen;
  logic [CW-1:0] cell_idx;
  logic running, chain_out, stop_valid;
  logic [PW-1:0] stop_pos;

  always #2.5 clk = ~clk;

  casc_ring_wr #(.NUM_CH(NCH), .CELLS(CELLS)) u0 (
    .clk(clk), .rst(rst), .arm_start(arm_start), .stop_req(stop_req),
    .part_sel(part_sel), .cascade_en(cascade_en), .free_run(free_run),
    .chain_in(chain_in), .ch_wen(ch_wen), .cell_idx(cell_idx), .running(running),
    .chain_out(chain_out), .stop_valid(stop_valid), .stop_pos(stop_pos));

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  string tag = "R1";

  // bench model: state 0 stopped, 1 running, 2 waiting; position within ring
  int mst = 0, mpos = 0, mpart = 0, mcasc = 0, mchain = 0, msv = 0, mspos = 0;

  function automatic logic [NCH-1:0] exp_wen(input int st, input int pos, input int part);
    logic [NCH-1:0] r;
    for (int c = 0; c < NCH; c++) r[c] = (st == 1) && ((c % (1 << part)) == pos / CELLS);
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mst = 0; mpos = 0; mpart = 0; mcasc = 0; mchain = 0; msv = 0;
    end else begin
      bit se;
      se = stop_req && !free_run;
      mchain = 0; msv = 0;
      case (mst)
        0: begin
          if (arm_start || (cascade_en && chain_in)) begin mst = 1; mpos = 0; end
          mpart = part_sel; mcasc = cascade_en;
        end
        1: begin
          if (se) begin msv = 1; mspos = mpos; mst = 0; mpos = 0; end
          else if (mpos == (CELLS << mpart) - 1) begin
            mpos = 0;
            if (mcasc) begin mst = 2; mchain = 1; end
          end else mpos = mpos + 1;
        end
        default: begin
          if (se) mst = 0;
          else if (chain_in) begin mst = 1; mpos = 0; end
        end
      endcase
    end
  end

  task automatic chk(input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("ch_wen", ch_wen, exp_wen(mst, mpos, mpart));
      chk("cell_idx", cell_idx, (mst == 1) ? (mpos % CELLS) : 0);
      chk("running", running, mst == 1);
      chk("chain_out", chain_out, mchain);
      chk("stop_valid", stop_valid, msv);
      if (msv) chk("stop_pos", stop_pos, mspos);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  task automatic ncyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_start(); arm_start = 1; ncyc(1); arm_start = 0; endtask
  task automatic pulse_stop();  stop_req = 1;  ncyc(1); stop_req = 0;  endtask
  task automatic pulse_chain(); chain_in = 1;  ncyc(1); chain_in = 0;  endtask
  task automatic wait_cell(input int c);
    int g = 0;
    while (cell_idx != CW'(c) && g < 1000) begin ncyc(1); g++; end
  endtask
  task automatic wait_chain();
    int g = 0;
    while (!chain_out && g < 1000) begin ncyc(1); g++; end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    ncyc(3);
    rst = 0;
    // R1: reset state
    tag = "R1";
    n_cmp++;
    if (ch_wen !== '0 || running !== 0 || chain_out !== 0 || stop_valid !== 0 || cell_idx !== '0) begin
      n_bad++;
      $display("FAIL R1 reset: actual wen=%0h run=%0b expected all zero", ch_wen, running);
    end
    ncyc(2);
    // R2: start, part 0
    tag = "R2"; part_sel = 0; pulse_start(); ncyc(4);
    tag = "R4"; ncyc(20); pulse_stop(); ncyc(2);
    // R3: hand-off inside group of two
    tag = "R3"; part_sel = 1; pulse_start(); ncyc(24);
    tag = "R4"; ncyc(20);
    // R13: start while running
    tag = "R13"; pulse_start(); ncyc(3);
    // R10: config changes while running
    tag = "R10"; part_sel = 3; cascade_en = 1; ncyc(40);
    // R8: stop
    tag = "R8"; pulse_stop(); ncyc(3);
    cascade_en = 0;
    // R5: each partition
    tag = "R5";
    for (int k = 0; k < 4; k++) begin
      part_sel = 2'(k); pulse_start(); ncyc((CELLS << k) + 7); pulse_stop(); ncyc(2);
    end
    // R9: stop on last cell of ring (wrap) and on channel hand-off
    tag = "R9"; part_sel = 0; pulse_start(); wait_cell(CELLS - 1); pulse_stop(); ncyc(3);
    part_sel = 2; pulse_start(); wait_cell(CELLS - 1); pulse_stop(); ncyc(3);
    cascade_en = 1; part_sel = 1; pulse_start(); ncyc(CELLS); wait_cell(CELLS - 1);
    pulse_stop(); ncyc(3);
    // R11: free running ignores stop
    tag = "R11"; cascade_en = 0; part_sel = 0; free_run = 1; pulse_start();
    ncyc(5); pulse_stop(); ncyc(5); pulse_stop(); ncyc(5);
    free_run = 0; pulse_stop(); ncyc(2);
    // R6: cascade hand-off and re-entry
    tag = "R6"; cascade_en = 1; part_sel = 1; pulse_start(); wait_chain(); ncyc(4);
    pulse_chain(); ncyc(10);
    // idle device entered via chain_in
    pulse_stop(); ncyc(2); pulse_chain(); ncyc(5); pulse_stop(); ncyc(2);
    // R12: stop and chain_in together while waiting
    tag = "R12"; part_sel = 0; pulse_start(); wait_chain(); ncyc(2);
    stop_req = 1; chain_in = 1; ncyc(1); stop_req = 0; chain_in = 0; ncyc(4);
    // R7: chain_in with cascade off
    tag = "R7"; cascade_en = 0; pulse_chain(); ncyc(4);
    // random mix
    tag = "R5";
    for (int i = 0; i < 4000; i++) begin
      arm_start  = ($urandom % 40) == 0;
      stop_req   = ($urandom % 70) == 0;
      chain_in   = ($urandom % 30) == 0;
      if (($urandom % 50) == 0) part_sel = 2'($urandom % 4);
      if (($urandom % 80) == 0) cascade_en = ~cascade_en;
      if (($urandom % 100) == 0) free_run = ~free_run;
      ncyc(1);
    end
    arm_start = 0; stop_req = 0; chain_in = 0; free_run = 0;
    ncyc(3);
    finish_run();
  end
endmodule